// File: doc/BRIEF.md
# SDRAM Single Read Sequencer with Clock-Suspend Data Stretch

This block runs one SDRAM read from start to finish: it closes all banks, opens the requested row, issues the column read, waits out a CAS latency of two, and then presents a data-valid window. When the access is a single-address DMA read into the contiguous SDRAM region, it can lengthen that window. It does this by pulling CKE low for a programmable number of clock-suspend states, which keeps the read data on the bus longer for a slow receiver.

A request is accepted only while the sequencer is idle. The addresses and all configuration inputs are latched on the accepting clock edge. The stretch needs four conditions together: the suspend enable, the output-enable control bit, the DMA single-address access type and the SDRAM-region flag. The 2-bit stretch field selects one to four suspend states. The data-delay configuration bits are accepted at the port but have no effect on the stretch.

Top module: `sdram_rd_seq`

## Requirements
- R1: After reset, and whenever idle, the outputs are NOP ({rasN,casN,weN}=111), cke=1, dqmN=11, addr=0, dmaAck=0 and capStrobe=0.
- R2: An accepted request produces one state per cycle, starting in the first cycle after the accepting edge. The order is: precharge-all ({rasN,casN,weN}=010, addr bit 10 = 1, all other addr bits 0); activate (011, addr = row); read (101, addr = column zero-extended, bit 10 = 0); latency NOP; then the data state.
- R3: Suspend states follow the data state only when suspendEn, oeCtl, dmaSingle and sdramSpace were all 1 at acceptance. Otherwise the data state is followed directly by the closing NOP.
- R4: When the stretch is active, the number of suspend states is extCount+1: 00 gives 1 state and 11 gives 4.
- R5: With oeCtl=0, no suspend state is inserted, whatever the other bits are.
- R6: The value of dataDelay does not change the number of suspend states or any output.
- R7: In every suspend state cke=0 and the command is NOP. cke=1 in every other state.
- R8: capStrobe is 1 from the data state through the last suspend state and 0 otherwise. dmaAck follows the same window, but only for DMA single-address accesses.
- R9: After the last window state, one NOP state (dqmN=11) returns the block to idle. A request raised while busy is ignored.
- R10: dqmN is 00 from the read state through the last window state, and 11 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Start a read (sampled while idle) |
| rowAddr | input | 13 | Row address |
| colAddr | input | 9 | Column address |
| dmaSingle | input | 1 | Access is a DMA single-address transfer |
| sdramSpace | input | 1 | Access targets the contiguous SDRAM region |
| suspendEn | input | 1 | Clock-suspend stretch enable |
| extCount | input | 2 | Stretch length minus one |
| oeCtl | input | 1 | Output-enable control; must be 1 for a stretch |
| dataDelay | input | 2 | Data-delay setting, no effect on the stretch |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| cke | output | 1 | SDRAM clock enable |
| dqmN | output | 2 | Byte masks (1 = masked) |
| addr | output | 13 | SDRAM address bus |
| dmaAck | output | 1 | DMA acknowledge |
| capStrobe | output | 1 | Read-data capture window |

## Verification
All outputs are decoded from registered state, so a result is due in the cycle after the edge that moves the state. Precharge appears in the first cycle after the accepting edge, and state k of the run appears k cycles later. The bench drives inputs on falling edges and samples every output on the falling edge that follows each rising edge. It compares the whole output word against a sequence computed from the run length 5+N+1, where N is 0 or extCount+1. The check continues one cycle past the closing NOP, so both a missing suspend state and an extra one are caught.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_TP, S_TR, S_TC1, S_TCL, S_TC2, S_TSP, S_TNOP
  } seqState_e;

  // {rasN, casN, weN}, active low
  typedef enum logic [2:0] {
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } sdCmd_e;

  typedef struct packed {
    logic   loadAddr;
    sdCmd_e cmd;
    logic   drivePall;
    logic   driveRow;
    logic   driveCol;
    logic   openMask;
    logic   suspend;
    logic   window;
    logic   ackEn;
  } seqStrobe_t;

endpackage

// File: rtl/sdram_rd_ctrl.sv
module sdram_rd_ctrl
  import sdram_rd_pkg::*;
#(
  parameter int EXT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             dmaSingle,
  input  logic             sdramSpace,
  input  logic             suspendEn,
  input  logic             oeCtl,
  input  logic [EXT_W-1:0] extCount,
  output seqStrobe_t       strobe
);

  seqState_e        state, stateNext;
  logic [EXT_W-1:0] susCntQ, susMaxQ;
  logic             extOnQ, dmaQ;
  logic             accept;

  assign accept = (state == S_IDLE) && reqValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      susCntQ <= '0;
      susMaxQ <= '0;
      extOnQ  <= 1'b0;
      dmaQ    <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) begin
        extOnQ  <= suspendEn && oeCtl && dmaSingle && sdramSpace;
        susMaxQ <= extCount;
        dmaQ    <= dmaSingle;
      end
      if (state == S_TC2)      susCntQ <= '0;
      else if (state == S_TSP) susCntQ <= susCntQ + 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE: if (reqValid) stateNext = S_TP;
      S_TP:   stateNext = S_TR;
      S_TR:   stateNext = S_TC1;
      S_TC1:  stateNext = S_TCL;
      S_TCL:  stateNext = S_TC2;
      S_TC2:  stateNext = extOnQ ? S_TSP : S_TNOP;
      S_TSP:  if (susCntQ == susMaxQ) stateNext = S_TNOP;
      S_TNOP: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    strobe          = '0;
    strobe.cmd      = CMD_NOP;
    strobe.loadAddr = accept;
    unique case (state)
      S_TP:  begin strobe.cmd = CMD_PRE; strobe.drivePall = 1'b1; end
      S_TR:  begin strobe.cmd = CMD_ACT; strobe.driveRow = 1'b1; end
      S_TC1: begin strobe.cmd = CMD_RD; strobe.driveCol = 1'b1; strobe.openMask = 1'b1; end
      S_TCL: strobe.openMask = 1'b1;
      S_TC2: begin
        strobe.openMask = 1'b1;
        strobe.window   = 1'b1;
        strobe.ackEn    = dmaQ;
      end
      S_TSP: begin
        strobe.openMask = 1'b1;
        strobe.window   = 1'b1;
        strobe.ackEn    = dmaQ;
        strobe.suspend  = 1'b1;
      end
      default: ;
    endcase
  end

  a_r2_tp_to_tr:   assert property (@(posedge clk) disable iff (!rstN) state == S_TP  |=> state == S_TR);
  a_r2_tr_to_tc1:  assert property (@(posedge clk) disable iff (!rstN) state == S_TR  |=> state == S_TC1);
  a_r2_tc1_to_tcl: assert property (@(posedge clk) disable iff (!rstN) state == S_TC1 |=> state == S_TCL);
  a_r2_tcl_to_tc2: assert property (@(posedge clk) disable iff (!rstN) state == S_TCL |=> state == S_TC2);
  a_r3_no_stretch: assert property (@(posedge clk) disable iff (!rstN)
                     (state == S_TC2 && !extOnQ) |=> state == S_TNOP);
  a_r4_last_suspend: assert property (@(posedge clk) disable iff (!rstN)
                     (state == S_TSP && susCntQ == susMaxQ) |=> state == S_TNOP);
  a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rstN)
                     state != S_IDLE |=> state != S_TP);
  a_r9_nop_to_idle: assert property (@(posedge clk) disable iff (!rstN) state == S_TNOP |=> state == S_IDLE);

endmodule

// File: rtl/sdram_rd_dpath.sv
module sdram_rd_dpath
  import sdram_rd_pkg::*;
#(
  parameter int ROW_W    = 13,
  parameter int COL_W    = 9,
  parameter int ADDR_W   = 13,
  parameter int DQM_W    = 2,
  parameter int PALL_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ROW_W-1:0]  rowAddr,
  input  logic [COL_W-1:0]  colAddr,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              cke,
  output logic [DQM_W-1:0]  dqmN,
  output logic [ADDR_W-1:0] addr,
  output logic              dmaAck,
  output logic              capStrobe
);

  localparam logic [ADDR_W-1:0] PALL_MASK = ADDR_W'(1) << PALL_BIT;

  logic [ROW_W-1:0]  rowQ;
  logic [COL_W-1:0]  colQ;
  logic [ADDR_W-1:0] rowExt, colExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ <= '0;
      colQ <= '0;
    end else if (strobe.loadAddr) begin
      rowQ <= rowAddr;
      colQ <= colAddr;
    end
  end

  assign rowExt = ADDR_W'(rowQ);
  assign colExt = ADDR_W'(colQ) & ~PALL_MASK;

  always_comb begin
    addr = '0;
    if (strobe.drivePall)     addr = PALL_MASK;
    else if (strobe.driveRow) addr = rowExt;
    else if (strobe.driveCol) addr = colExt;
  end

  assign {rasN, casN, weN} = strobe.cmd;
  assign cke       = ~strobe.suspend;
  assign dqmN      = strobe.openMask ? '0 : '1;
  assign capStrobe = strobe.window;
  assign dmaAck    = strobe.ackEn;

  a_r7_suspend_is_nop: assert property (@(posedge clk) disable iff (!rstN)
                       !cke |-> {rasN, casN, weN} == 3'b111);
  a_r7_suspend_in_window: assert property (@(posedge clk) disable iff (!rstN) !cke |-> capStrobe);
  a_r8_ack_in_window: assert property (@(posedge clk) disable iff (!rstN) dmaAck |-> capStrobe);
  a_r10_mask_open: assert property (@(posedge clk) disable iff (!rstN) capStrobe |-> dqmN == '0);
  a_r2_act_then_read: assert property (@(posedge clk) disable iff (!rstN)
                      {rasN, casN, weN} == 3'b011 |=> {rasN, casN, weN} == 3'b101);

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int ROW_W    = 13,
  parameter int COL_W    = 9,
  parameter int ADDR_W   = 13,
  parameter int DQM_W    = 2,
  parameter int EXT_W    = 2,
  parameter int DLY_W    = 2,
  parameter int PALL_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ROW_W-1:0]  rowAddr,
  input  logic [COL_W-1:0]  colAddr,
  input  logic              dmaSingle,
  input  logic              sdramSpace,
  input  logic              suspendEn,
  input  logic [EXT_W-1:0]  extCount,
  input  logic              oeCtl,
  input  logic [DLY_W-1:0]  dataDelay,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              cke,
  output logic [DQM_W-1:0]  dqmN,
  output logic [ADDR_W-1:0] addr,
  output logic              dmaAck,
  output logic              capStrobe
);

  seqStrobe_t strobe;

  sdram_rd_ctrl #(.EXT_W(EXT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .dmaSingle  (dmaSingle),
    .sdramSpace (sdramSpace),
    .suspendEn  (suspendEn),
    .oeCtl      (oeCtl),
    .extCount   (extCount),
    .strobe     (strobe)
  );

  sdram_rd_dpath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .DQM_W(DQM_W), .PALL_BIT(PALL_BIT)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rowAddr   (rowAddr),
    .colAddr   (colAddr),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN),
    .cke       (cke),
    .dqmN      (dqmN),
    .addr      (addr),
    .dmaAck    (dmaAck),
    .capStrobe (capStrobe)
  );

  // R6: the data-delay setting only has to be a defined level; nothing decodes it
  a_r6_delay_defined: assert property (@(posedge clk) disable iff (!rstN) !$isunknown(dataDelay));

endmodule

// File: tb/sdram_rd_seq_bench.sv
module sdram_rd_seq_bench;

  localparam int NV = 14;
  // [10]suspendEn [9]oeCtl [8]dmaSingle [7]sdramSpace [6:5]extCount [4:3]dataDelay [2:0]expected suspend states
  localparam logic [10:0] VEC [NV] = '{
    11'b1111_00_00_001, 11'b1111_01_00_010, 11'b1111_10_00_011, 11'b1111_11_00_100,
    11'b0111_00_01_000, 11'b0111_01_10_000, 11'b0111_10_11_000, 11'b0111_11_00_000,
    11'b1011_10_00_000, 11'b1101_11_00_000, 11'b1110_01_00_000,
    11'b1111_01_01_010, 11'b1111_01_10_010, 11'b1111_01_11_010
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [12:0] rowAddr = '0;
  logic [8:0]  colAddr = '0;
  logic        dmaSingle = 1'b0, sdramSpace = 1'b0, suspendEn = 1'b0, oeCtl = 1'b0;
  logic [1:0]  extCount = '0, dataDelay = '0;
  logic        rasN, casN, weN, cke, dmaAck, capStrobe;
  logic [1:0]  dqmN;
  logic [12:0] addr;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sdram_rd_seq u_sdram_rd_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rowAddr(rowAddr), .colAddr(colAddr),
    .dmaSingle(dmaSingle), .sdramSpace(sdramSpace), .suspendEn(suspendEn),
    .extCount(extCount), .oeCtl(oeCtl), .dataDelay(dataDelay),
    .rasN(rasN), .casN(casN), .weN(weN), .cke(cke), .dqmN(dqmN), .addr(addr),
    .dmaAck(dmaAck), .capStrobe(capStrobe)
  );

  localparam logic [20:0] IDLE_WORD = {3'b111, 1'b1, 2'b11, 1'b0, 1'b0, 13'h0};

  function automatic logic [20:0] observed();
    return {rasN, casN, weN, cke, dqmN, dmaAck, capStrobe, addr};
  endfunction

  // expected output word k cycles into the run (k=0 is precharge)
  function automatic logic [20:0] expectAt(int k, int n, logic dma, logic [12:0] row, logic [8:0] col);
    if (k == 0) return {3'b010, 1'b1, 2'b11, 1'b0, 1'b0, 13'h0400};
    if (k == 1) return {3'b011, 1'b1, 2'b11, 1'b0, 1'b0, row};
    if (k == 2) return {3'b101, 1'b1, 2'b00, 1'b0, 1'b0, 4'h0, col};
    if (k == 3) return {3'b111, 1'b1, 2'b00, 1'b0, 1'b0, 13'h0};
    if (k == 4) return {3'b111, 1'b1, 2'b00, dma, 1'b1, 13'h0};
    if (k <= 4 + n) return {3'b111, 1'b0, 2'b00, dma, 1'b1, 13'h0};
    return IDLE_WORD;
  endfunction

  function automatic string vecTag(int i);
    if (i < 4) return "R3 R4 R7";
    if (i < 8) return "R3";
    if (i == 8) return "R5";
    if (i < 11) return "R3";
    return "R6";
  endfunction

  function automatic string cycTag(int k, int n, string vt);
    if (k <= 1) return "R2";
    if (k == 2) return "R2 R10";
    if (k == 3) return "R10";
    if (k <= 4 + n) return {vt, " R8 R10"};
    return "R9";
  endfunction

  task automatic check(string tag, logic [20:0] got, logic [20:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic runOp(int idx, logic [10:0] v, logic [12:0] row, logic [8:0] col, int pokeAt);
    int n;
    n = int'(v[2:0]);
    @(negedge clk);
    {suspendEn, oeCtl, dmaSingle, sdramSpace} = v[10:7];
    extCount  = v[6:5];
    dataDelay = v[4:3];
    rowAddr   = row;
    colAddr   = col;
    reqValid  = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k <= 7 + n; k++) begin
      if (k == pokeAt) begin reqValid = 1'b1; rowAddr = ~row; end
      else reqValid = 1'b0;
      check($sformatf("%s vec %0d cycle %0d", cycTag(k, n, vecTag(idx)), idx, k),
            observed(), expectAt(k, n, v[8], row, col));
      @(negedge clk);
    end
    reqValid = 1'b0;
  endtask

  initial begin
    #(50000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1;
    // R1: reset state, before and after release
    check("R1 in reset", observed(), IDLE_WORD);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", observed(), IDLE_WORD);

    for (int i = 0; i < NV; i++) begin
      runOp(i, VEC[i], 13'h1C00 | 13'(i * 37), 9'h0F0 ^ 9'(i * 5), -1);
    end

    // R9: a request raised in mid-run is ignored; the run stays unchanged and ends idle
    runOp(3, VEC[3], 13'h0ABC, 9'h155, 2);
    for (int k = 0; k < 3; k++) begin
      check("R9 no restart after busy request", observed(), IDLE_WORD);
      @(negedge clk);
    end

    // R1: reset in the middle of a stretch returns to idle outputs at once
    @(negedge clk);
    {suspendEn, oeCtl, dmaSingle, sdramSpace} = 4'b1111;
    extCount = 2'b11;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 suspend reached before reset", {31'b0, cke}, 32'b0);
    rstN = 1'b0;
    #1;
    check("R1 reset during suspend", observed(), IDLE_WORD);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after mid-run reset", observed(), IDLE_WORD);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule